// File: doc/BRIEF.md
# Packet Commit Store Sequencer

This block finishes a wide-issue packet by making its memory side effects and buffered state changes visible in a fixed order. A single `start` pulse launches a commit. The caller holds the packet's commit information on the inputs until `done`. That information is a two-slot store log, predication and cancellation flags, an optional cache-line zeroing request, a permission answer for the slot 0 address, the predicate write log and the per-instruction counting flags.

The sequencer issues at most one write per cycle on a plain write port. Each write carries an 8-byte-aligned word address, byte enables and lane-placed data. The order is fixed: slot 1 goes before slot 0, or the four words of a zeroed line are written in place of both. Next the sequencer pulses a strobe so that the external register file copies its buffered values. Then it updates its own predicate bank and the packet and instruction counters. Finally it pulses `done`.

If the packet is malformed or a permission check fails, the commit is blocked. In that case nothing at all is written or updated, and a flag explains why.

Top module: `pkt_commit_seq`

## Requirements
- R1: When both slots hold a store that is to be written, the slot 1 write appears on the port in the cycle before the slot 0 write.
- R2: A store is skipped when its predicated flag is set and its cancel bit is set (bit 0 of `s_pred` and `cancel_mask` belongs to slot 0, bit 1 to slot 1). A store that is unpredicated, or predicated but not cancelled, is written.
- R3: Width codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. `mem_addr` is the store address with bits 2:0 cleared. The byte enables cover `width` bytes starting at lane `addr[2:0]`. The data for the 8-byte width comes from the 64-bit field; the other widths take the low bytes of the 32-bit field. Disabled lanes carry zero.
- R4: A line-zero request in a packet whose only store is slot 0 produces exactly four writes. They go to `lz_addr` with its low 5 bits cleared, plus 0, 8, 16 and 24, in that order, each with all byte enables set and zero data. No slot store is written.
- R5: A line-zero request when slot 0 has no store, or when slot 1 has a store, raises `err`. The commit is then blocked.
- R6: When both slots hold a store (valid, whether cancelled or not), no line-zero request is present and `s0_probe_ok` is low at start, `fault` is raised and the commit is blocked.
- R7: In an unblocked commit, the first write occurs in the cycle after `start`. `reg_commit` pulses in the cycle after the last write, or in the cycle after `start` if there are no writes. The predicates and counters update at the end of the following cycle, and `done` pulses for one cycle in the cycle after that. In a blocked commit, `done` pulses in the cycle after `start`. There are then no writes and no `reg_commit`, and the predicates and counters do not change.
- R8: Without the end-of-loop flag, every predicate whose `plog_mask` bit is set takes its new value, and the other predicates keep their values.
- R9: With the end-of-loop flag set, a logged predicate is updated only if its `pwritten_mask` bit is also set.
- R10: Each committed packet adds one to `pkt_count`. It also adds to `insn_count` the number of instructions whose `insn_valid` bit is set and whose `insn_skip` bit is clear.
- R11: After reset, there are no writes, the predicates and both counters are zero, and `done`, `busy`, `fault` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin committing the packet presented on the inputs |
| s_valid | input | 2 | Store present per slot |
| s_pred | input | 2 | Store is predicated, per slot |
| cancel_mask | input | 2 | Slot-cancelled bits |
| s0_width | input | 2 | Slot 0 width code |
| s0_addr | input | AW | Slot 0 byte address |
| s0_data32 | input | 32 | Slot 0 narrow data |
| s0_data64 | input | 64 | Slot 0 wide data |
| s1_width | input | 2 | Slot 1 width code |
| s1_addr | input | AW | Slot 1 byte address |
| s1_data32 | input | 32 | Slot 1 narrow data |
| s1_data64 | input | 64 | Slot 1 wide data |
| lz_req | input | 1 | Zero a 32-byte line instead of the slot stores |
| lz_addr | input | AW | Any address within the line to zero |
| s0_probe_ok | input | 1 | Slot 0 address may be written |
| endloop | input | 1 | Packet contains an end-of-loop instruction |
| plog_mask | input | NPRED | Predicates written by the packet |
| pwritten_mask | input | NPRED | Predicates actually produced at run time |
| new_pred | input | NPRED*PW | New predicate values, predicate i at bits i*PW |
| insn_valid | input | NINSN | Instruction present per position |
| insn_skip | input | NINSN | Instruction is a loop marker, second half or no-op |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | AW | 8-byte-aligned word address |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Lane-placed write data |
| reg_commit | output | 1 | Copy buffered register values now |
| pred_q | output | NPRED*PW | Predicate bank |
| pkt_count | output | CW | Committed packet count |
| insn_count | output | CW | Committed instruction count |
| busy | output | 1 | Commit in progress |
| done | output | 1 | Commit finished |
| fault | output | 1 | Last commit blocked by a permission failure |
| err | output | 1 | Last commit blocked by a misplaced line-zero |

## Verification
The store path is tried with dual stores whose order alone separates a correct design from one that swaps the slots. It is also tried with single stores in each slot, and with every cancel and predicate pairing, which tells a skipped store from a written one and a cancel bit that applies to the wrong slot. Narrow and wide widths at unaligned lane offsets expose mistakes in byte-enable placement and in the choice of data field. Line-zero packets, with legal and illegal slot contents, and a denied permission check separate the blocked outcomes from the committed ones. Directed packets with and without the end-of-loop flag show whether the predicate-written mask gates the update.

// File: rtl/pcs_pkg.sv
// Shared types for the packet commit store sequencer.
package pcs_pkg;
    // Phases of one commit, visited in this order
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ST1,
        PH_ST0,
        PH_ZERO,
        PH_REGW,
        PH_PREDW,
        PH_DONE
    } phase_e;

    localparam int LANES     = 8;
    localparam int ZERO_BEAT = 4;
endpackage

// File: rtl/pcs_lane_fmt.sv
// Places one store onto the 8-byte write port: word address, byte enables
// and lane data. Assumes the address is naturally aligned to the width.
module pcs_lane_fmt #(
    parameter int AW = 32
) (
    input  logic [1:0]    width_code,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   d32,
    input  logic [63:0]   d64,
    output logic [AW-1:0] word_addr,
    output logic [7:0]    be,
    output logic [63:0]   data
);
    logic [63:0] src;
    logic [3:0]  nbytes;
    logic [2:0]  off;

    // Pick the data field and the byte count from the width code
    always_comb begin
        src    = (width_code == 2'd3) ? d64 : {32'b0, d32};
        nbytes = 4'd1 << width_code;
        off    = addr[2:0];
    end

    assign word_addr = {addr[AW-1:3], 3'b000};

    for (genvar b = 0; b < pcs_pkg::LANES; b++) begin : g_lane
        logic [2:0] rel;
        // Source byte index feeding this lane
        assign rel = 3'(b) - off;
        assign be[b] = (3'(b) >= off) && ({1'b0, rel} < nbytes);
        assign data[b*8 +: 8] = be[b] ? src[{rel, 3'b000} +: 8] : 8'h00;
    end
endmodule

// File: rtl/pcs_pred_bank.sv
// Predicate bank updated once per commit. Assumes en is a one-cycle pulse.
module pcs_pred_bank #(
    parameter int NPRED = 4,
    parameter int PW    = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                has_endloop,
    input  logic [NPRED-1:0]    log_mask,
    input  logic [NPRED-1:0]    written_mask,
    input  logic [NPRED*PW-1:0] new_val,
    output logic [NPRED*PW-1:0] pred_q
);
    for (genvar i = 0; i < NPRED; i++) begin : g_pred
        logic [PW-1:0] r;
        // Take the new value when logged and, under end-of-loop, produced
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= '0;
            else if (en && log_mask[i] && (!has_endloop || written_mask[i]))
                r <= new_val[i*PW +: PW];
        end
        assign pred_q[i*PW +: PW] = r;
    end

    // R8
    pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pred_q));
endmodule

// File: rtl/pcs_exec_count.sv
// Packet and instruction counters. Assumes en pulses once per commit.
module pcs_exec_count #(
    parameter int NINSN = 4,
    parameter int CW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [NINSN-1:0] insn_valid,
    input  logic [NINSN-1:0] insn_skip,
    output logic [CW-1:0]    pkt_cnt,
    output logic [CW-1:0]    insn_cnt
);
    localparam int SW = $clog2(NINSN + 1);
    logic [SW-1:0] real_n;

    // Count instructions that are present and not excluded
    always_comb begin
        real_n = '0;
        for (int i = 0; i < NINSN; i++)
            real_n = real_n + SW'(insn_valid[i] & ~insn_skip[i]);
    end

    // Advance both counters on a committed packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_cnt  <= '0;
            insn_cnt <= '0;
        end else if (en) begin
            pkt_cnt  <= pkt_cnt + CW'(1);
            insn_cnt <= insn_cnt + CW'(real_n);
        end
    end

    // R10
    pkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> pkt_cnt == $past(pkt_cnt) + CW'(1));
endmodule

// File: rtl/pkt_commit_seq.sv
// Commits one packet: stores (slot 1 then slot 0, or a zeroed line), then a
// register-copy strobe, then predicate and counter updates, then done.
// Assumes all packet inputs stay stable from start until done, and that the
// write port accepts one write every cycle.
module pkt_commit_seq
    import pcs_pkg::*;
#(
    parameter int AW    = 32,
    parameter int NPRED = 4,
    parameter int PW    = 1,
    parameter int NINSN = 4,
    parameter int CW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          s_valid,
    input  logic [1:0]          s_pred,
    input  logic [1:0]          cancel_mask,
    input  logic [1:0]          s0_width,
    input  logic [AW-1:0]       s0_addr,
    input  logic [31:0]         s0_data32,
    input  logic [63:0]         s0_data64,
    input  logic [1:0]          s1_width,
    input  logic [AW-1:0]       s1_addr,
    input  logic [31:0]         s1_data32,
    input  logic [63:0]         s1_data64,
    input  logic                lz_req,
    input  logic [AW-1:0]       lz_addr,
    input  logic                s0_probe_ok,
    input  logic                endloop,
    input  logic [NPRED-1:0]    plog_mask,
    input  logic [NPRED-1:0]    pwritten_mask,
    input  logic [NPRED*PW-1:0] new_pred,
    input  logic [NINSN-1:0]    insn_valid,
    input  logic [NINSN-1:0]    insn_skip,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [7:0]          mem_be,
    output logic [63:0]         mem_wdata,
    output logic                reg_commit,
    output logic [NPRED*PW-1:0] pred_q,
    output logic [CW-1:0]       pkt_count,
    output logic [CW-1:0]       insn_count,
    output logic                busy,
    output logic                done,
    output logic                fault,
    output logic                err
);
    localparam int ZCW = $clog2(ZERO_BEAT);

    phase_e         cur;
    logic [1:0]     eligible, do_q;
    logic [ZCW-1:0] zcnt;
    logic           fault_q, err_q, lz_bad, probe_bad;
    logic [AW-1:0]  a0, a1, zaddr;
    logic [7:0]     be0, be1;
    logic [63:0]    d0, d1;

    // Decide what this packet will do when it is launched
    always_comb begin
        eligible[0] = s_valid[0] && !(s_pred[0] && cancel_mask[0]);
        eligible[1] = s_valid[1] && !(s_pred[1] && cancel_mask[1]);
        lz_bad      = lz_req && (!s_valid[0] || s_valid[1]);
        probe_bad   = !lz_req && (s_valid == 2'b11) && !s0_probe_ok;
        zaddr       = (lz_addr & ~AW'(31)) + AW'({zcnt, 3'b000});
    end

    pcs_lane_fmt #(.AW(AW)) u_lane0 (
        .width_code(s0_width), .addr(s0_addr), .d32(s0_data32), .d64(s0_data64),
        .word_addr(a0), .be(be0), .data(d0)
    );

    pcs_lane_fmt #(.AW(AW)) u_lane1 (
        .width_code(s1_width), .addr(s1_addr), .d32(s1_data32), .d64(s1_data64),
        .word_addr(a1), .be(be1), .data(d1)
    );

    // Commit phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur     <= PH_IDLE;
            do_q    <= '0;
            zcnt    <= '0;
            fault_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (cur)
                PH_IDLE: if (start) begin
                    fault_q <= probe_bad;
                    err_q   <= lz_bad;
                    do_q    <= eligible;
                    zcnt    <= '0;
                    if (lz_bad || probe_bad) cur <= PH_DONE;
                    else if (lz_req)         cur <= PH_ZERO;
                    else if (eligible[1])    cur <= PH_ST1;
                    else if (eligible[0])    cur <= PH_ST0;
                    else                     cur <= PH_REGW;
                end
                PH_ST1:  cur <= do_q[0] ? PH_ST0 : PH_REGW;
                PH_ST0:  cur <= PH_REGW;
                PH_ZERO: begin
                    zcnt <= zcnt + ZCW'(1);
                    if (zcnt == ZCW'(ZERO_BEAT - 1)) cur <= PH_REGW;
                end
                PH_REGW:  cur <= PH_PREDW;
                PH_PREDW: cur <= PH_DONE;
                default:  cur <= PH_IDLE;
            endcase
        end
    end

    // Drive the write port from the current phase
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        case (cur)
            PH_ST1:  begin mem_we = 1'b1; mem_addr = a1; mem_be = be1; mem_wdata = d1; end
            PH_ST0:  begin mem_we = 1'b1; mem_addr = a0; mem_be = be0; mem_wdata = d0; end
            PH_ZERO: begin mem_we = 1'b1; mem_addr = zaddr; mem_be = 8'hFF; end
            default: ;
        endcase
    end

    assign reg_commit = (cur == PH_REGW);
    assign busy       = (cur != PH_IDLE);
    assign done       = (cur == PH_DONE);
    assign fault      = fault_q;
    assign err        = err_q;

    pcs_pred_bank #(.NPRED(NPRED), .PW(PW)) u_pred (
        .clk(clk), .rst_n(rst_n), .en(cur == PH_PREDW), .has_endloop(endloop),
        .log_mask(plog_mask), .written_mask(pwritten_mask), .new_val(new_pred),
        .pred_q(pred_q)
    );

    pcs_exec_count #(.NINSN(NINSN), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(cur == PH_PREDW),
        .insn_valid(insn_valid), .insn_skip(insn_skip),
        .pkt_cnt(pkt_count), .insn_cnt(insn_count)
    );

    // R1
    slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == PH_ST0 && do_q[1]) |-> $past(cur) == PH_ST1);

    // R2
    cancel_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == PH_ST1) |-> !(s_pred[1] && cancel_mask[1]));

    // R2
    cancel_skip0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == PH_ST0) |-> !(s_pred[0] && cancel_mask[0]));

    // R4
    zero_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == PH_ZERO && zcnt != '0) |-> mem_addr == $past(mem_addr) + AW'(8));

    // R6
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_q || err_q) && busy) |-> (!mem_we && !reg_commit));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/pkt_commit_seq_bench.sv
module pkt_commit_seq_bench;
    localparam int AW = 32, NPRED = 4, PW = 1, NINSN = 4, CW = 32;

    typedef struct packed {
        logic [1:0]  v, p, c, w1;
        logic [31:0] a1;
        logic [63:0] d1;
        logic [1:0]  w0;
        logic [31:0] a0;
        logic [63:0] d0;
        logic        lz;
        logic [31:0] lza;
        logic        ok;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'b11, 2'b00, 2'b00, 2'd2, 32'h100, 64'hA1B2C3D4, 2'd0, 32'h103, 64'h55, 1'b0, 32'h0, 1'b1},
        '{2'b01, 2'b00, 2'b00, 2'd0, 32'h0, 64'h0, 2'd3, 32'h208, 64'h0123456789ABCDEF, 1'b0, 32'h0, 1'b1},
        '{2'b10, 2'b00, 2'b00, 2'd1, 32'h306, 64'hBEEF, 2'd0, 32'h0, 64'h0, 1'b0, 32'h0, 1'b1},
        '{2'b11, 2'b10, 2'b10, 2'd2, 32'h400, 64'h11112222, 2'd2, 32'h404, 64'h33334444, 1'b0, 32'h0, 1'b1},
        '{2'b11, 2'b11, 2'b01, 2'd0, 32'h501, 64'h77, 2'd1, 32'h502, 64'h9988, 1'b0, 32'h0, 1'b1},
        '{2'b11, 2'b01, 2'b10, 2'd3, 32'h608, 64'hFEDCBA9876543210, 2'd1, 32'h60A, 64'hABCD, 1'b0, 32'h0, 1'b1},
        '{2'b11, 2'b00, 2'b00, 2'd2, 32'h700, 64'h1, 2'd2, 32'h704, 64'h2, 1'b0, 32'h0, 1'b0},
        '{2'b01, 2'b00, 2'b00, 2'd0, 32'h0, 64'h0, 2'd0, 32'h0, 64'h0, 1'b1, 32'h12345677, 1'b1},
        '{2'b11, 2'b00, 2'b00, 2'd0, 32'h0, 64'h0, 2'd0, 32'h0, 64'h0, 1'b1, 32'h800, 1'b1},
        '{2'b00, 2'b00, 2'b00, 2'd0, 32'h0, 64'h0, 2'd0, 32'h0, 64'h0, 1'b1, 32'h900, 1'b1},
        '{2'b00, 2'b00, 2'b00, 2'd0, 32'h0, 64'h0, 2'd0, 32'h0, 64'h0, 1'b0, 32'h0, 1'b1},
        '{2'b11, 2'b11, 2'b11, 2'd0, 32'hA00, 64'h1, 2'd0, 32'hA01, 64'h2, 1'b0, 32'h0, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [1:0] s_valid, s_pred, cancel_mask, s0_width, s1_width;
    logic [AW-1:0] s0_addr, s1_addr, lz_addr;
    logic [31:0] s0_data32, s1_data32;
    logic [63:0] s0_data64, s1_data64;
    logic lz_req, s0_probe_ok, endloop;
    logic [NPRED-1:0] plog_mask, pwritten_mask;
    logic [NPRED*PW-1:0] new_pred, pred_q;
    logic [NINSN-1:0] insn_valid, insn_skip;
    logic mem_we, reg_commit, busy, done, fault, err;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_be;
    logic [63:0] mem_wdata;
    logic [CW-1:0] pkt_count, insn_count;

    int nchk = 0, nfail = 0, exp_pkts = 0, exp_insns = 0;

    always #10 clk = ~clk;

    pkt_commit_seq #(.AW(AW), .NPRED(NPRED), .PW(PW), .NINSN(NINSN), .CW(CW)) u_pkt_commit_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid), .s_pred(s_pred),
        .cancel_mask(cancel_mask), .s0_width(s0_width), .s0_addr(s0_addr),
        .s0_data32(s0_data32), .s0_data64(s0_data64), .s1_width(s1_width),
        .s1_addr(s1_addr), .s1_data32(s1_data32), .s1_data64(s1_data64),
        .lz_req(lz_req), .lz_addr(lz_addr), .s0_probe_ok(s0_probe_ok),
        .endloop(endloop), .plog_mask(plog_mask), .pwritten_mask(pwritten_mask),
        .new_pred(new_pred), .insn_valid(insn_valid), .insn_skip(insn_skip),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .reg_commit(reg_commit), .pred_q(pred_q), .pkt_count(pkt_count),
        .insn_count(insn_count), .busy(busy), .done(done), .fault(fault), .err(err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Expected placement of one store on the port (R3)
    task automatic slot_exp(input logic [1:0] w, input logic [31:0] a, input logic [63:0] d,
                            output logic [31:0] ea, output logic [7:0] eb, output logic [63:0] ed);
        int nb;
        logic [63:0] mask, src;
        logic [7:0] bm;
        nb   = 1 << w;
        mask = (w == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * nb)) - 64'd1);
        src  = (w == 2'd3) ? d : {32'b0, d[31:0]};
        bm   = 8'((16'd1 << nb) - 16'd1);
        eb   = bm << a[2:0];
        ed   = (src & mask) << (8 * int'(a[2:0]));
        ea   = {a[31:3], 3'b000};
    endtask

    task automatic run_pkt(input vec_t v, input int idx);
        logic [31:0] ea [4];
        logic [7:0]  eb [4];
        logic [63:0] ed [4];
        int n, wi, rc_k, dn_k;
        bit blk_err, blk_fault;
        string wreq;
        s_valid = v.v; s_pred = v.p; cancel_mask = v.c;
        s1_width = v.w1; s1_addr = v.a1; s1_data32 = v.d1[31:0]; s1_data64 = v.d1;
        s0_width = v.w0; s0_addr = v.a0; s0_data32 = v.d0[31:0]; s0_data64 = v.d0;
        lz_req = v.lz; lz_addr = v.lza; s0_probe_ok = v.ok;
        blk_err   = v.lz && (!v.v[0] || v.v[1]);
        blk_fault = !v.lz && (v.v == 2'b11) && !v.ok;
        n = 0;
        wreq = v.lz ? "R4" : "R3";
        if (!blk_err && !blk_fault) begin
            if (v.lz) begin
                for (int k = 0; k < 4; k++) begin
                    ea[k] = (v.lza & ~32'h1F) + 32'(8 * k);
                    eb[k] = 8'hFF;
                    ed[k] = 64'h0;
                end
                n = 4;
            end else begin
                if (v.v[1] && !(v.p[1] && v.c[1])) begin
                    slot_exp(v.w1, v.a1, v.d1, ea[n], eb[n], ed[n]); n++;
                end
                if (v.v[0] && !(v.p[0] && v.c[0])) begin
                    slot_exp(v.w0, v.a0, v.d0, ea[n], eb[n], ed[n]); n++;
                end
            end
            exp_pkts++;
            exp_insns += 3;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wi = 0; rc_k = -1; dn_k = -1;
        for (int k = 0; k < 16 && dn_k < 0; k++) begin
            if (mem_we) begin
                if (wi < n) begin
                    chk(mem_addr == ea[wi], wreq, 64'(mem_addr), 64'(ea[wi]));
                    chk(mem_be == eb[wi], wreq, 64'(mem_be), 64'(eb[wi]));
                    chk(mem_wdata == ed[wi], wreq, mem_wdata, ed[wi]);
                end
                wi++;
            end
            if (reg_commit) rc_k = k;
            if (done) dn_k = k;
            else @(negedge clk);
        end
        // R1 R2: number and order of writes
        chk(wi == n, "R1 R2 write count", 64'(wi), 64'(n));
        chk(fault == blk_fault, "R6", 64'(fault), 64'(blk_fault));
        chk(err == blk_err, "R5", 64'(err), 64'(blk_err));
        if (blk_err || blk_fault) begin
            chk(dn_k == 0, "R7 blocked done", 64'(dn_k), 64'd0);
            chk(rc_k == -1, "R7 blocked reg_commit", 64'(rc_k), 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
            chk(rc_k == n, "R7 reg_commit cycle", 64'(rc_k), 64'(n));
            chk(dn_k == n + 2, "R7 done cycle", 64'(dn_k), 64'(n + 2));
        end
        if (idx < 0) $display("pred packet");
        @(negedge clk);
    endtask

    initial begin
        vec_t z;
        z = '0;
        s_valid = '0; s_pred = '0; cancel_mask = '0; s0_width = '0; s1_width = '0;
        s0_addr = '0; s1_addr = '0; lz_addr = '0; s0_data32 = '0; s1_data32 = '0;
        s0_data64 = '0; s1_data64 = '0; lz_req = 1'b0; s0_probe_ok = 1'b1;
        endloop = 1'b0; plog_mask = '0; pwritten_mask = '0; new_pred = '0;
        insn_valid = 4'b1111; insn_skip = 4'b0100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!mem_we && !done && !busy, "R11 idle", {61'b0, mem_we, done, busy}, 64'd0);
        chk(!fault && !err, "R11 flags", {62'b0, fault, err}, 64'd0);
        chk(pkt_count == 0 && insn_count == 0, "R11 counters", 64'(pkt_count), 64'd0);
        chk(pred_q == 0, "R11 preds", 64'(pred_q), 64'd0);

        for (int i = 0; i < NV; i++) run_pkt(VECS[i], i);

        // R8: no end-of-loop, logged predicates written unconditionally
        plog_mask = 4'b0101; pwritten_mask = 4'b0000; new_pred = 4'b1111; endloop = 1'b0;
        run_pkt(z, -1);
        chk(pred_q == 4'b0101, "R8", 64'(pred_q), 64'h5);
        // R9: end-of-loop gates each logged predicate by its written bit
        plog_mask = 4'b1111; pwritten_mask = 4'b0011; new_pred = 4'b0000; endloop = 1'b1;
        run_pkt(z, -1);
        chk(pred_q == 4'b0100, "R9", 64'(pred_q), 64'h4);
        // R9: end-of-loop with nothing produced leaves the bank unchanged
        pwritten_mask = 4'b0000; new_pred = 4'b1011;
        run_pkt(z, -1);
        chk(pred_q == 4'b0100, "R9 none written", 64'(pred_q), 64'h4);
        plog_mask = '0; endloop = 1'b0;

        // R10: counters over all committed packets
        chk(pkt_count == CW'(exp_pkts), "R10 packets", 64'(pkt_count), 64'(exp_pkts));
        chk(insn_count == CW'(exp_insns), "R10 instructions", 64'(insn_count), 64'(exp_insns));
        // R10: different skip pattern adds two
        insn_valid = 4'b1011; insn_skip = 4'b0010;
        run_pkt(z, -1);
        exp_insns = exp_insns - 3 + 2;
        chk(insn_count == CW'(exp_insns), "R10 skip pattern", 64'(insn_count), 64'(exp_insns));

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule